// File: doc/BRIEF.md
# Serial Console Register Front End

This block is the byte-wide register face of a serial console. Software writes characters to a data register. The block drops codes that a terminal should not see and hands the rest, one at a time, to a downstream character sink over a valid/ready handshake. When the sink is still holding an earlier character, a new data write is held off with a stall signal, so no character is ever lost.

The block also keeps the interrupt state that a console driver expects. It holds an interrupt-enable register and a transmit-pending flag, decodes a command register whose acknowledge code clears that flag, and shows a status byte that combines transmit-pending with an externally supplied receive-pending input. A single interrupt line, the pending flags gated by their enables, goes to the system interrupt request controller. An acknowledge issued while nothing is pending is a driver protocol error, and it is latched on a sticky error output.

Register reads are combinational from the current state. Writes take effect at the clock edge on which `reg_wr` is high and `reg_stall` is low.

Top module: `con_uart_front`

## Requirements
- R1: After reset, `ch_valid`, `irq` and `ack_err` are 0, and reads of the enable register (offset 0x1), the command store (offset 0x3) and status (offset 0x5) return 0.
- R2: An accepted write to offset 0x0 of a printable code (0x20 to 0x7E) or a control code (0x00 to 0x1F, or 0x7F), other than 0x0C, is presented on `ch_data` with `ch_valid` high from the next cycle. Characters leave in write order.
- R3: An accepted write to offset 0x0 of 0x0C, or of any code from 0x80 to 0xFF, produces no character on the output.
- R4: `ch_valid` and `ch_data` are held until a cycle with `ch_ready` high. A write to offset 0x0 while `ch_valid` is high and `ch_ready` is low raises `reg_stall` and takes no effect until the stall clears.
- R5: Every accepted write to offset 0x0, including a dropped code, sets the transmit-pending flag when enable bit 1 (mask 0x02) is set. With that bit clear, it leaves the flag unchanged.
- R6: A write to offset 0x1 stores the enable byte, which reads back at offset 0x1. If bit 1 of the written value is set, the transmit-pending flag is set at once.
- R7: Writing 0x28 to offset 0x3 clears the transmit-pending flag. If the flag was already clear, `ack_err` is set instead, and it stays set until reset.
- R8: Any other write to offset 0x3 (such as 0x03, 0x00, 0x01 or 0x12) changes no pending flag. The last command byte reads back at offset 0x3.
- R9: Writes to offset 0x4 are accepted and change no readable state.
- R10: A read of offset 0x5 returns the transmit-pending flag in bit 0 and the `rx_pending` input in bit 1, with all other bits 0.
- R11: `irq` is high exactly when (transmit-pending and enable bit 1) or (`rx_pending` and enable bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| reg_stall | output | 1 | Write held off; keep the strobe and the data steady |
| rx_pending | input | 1 | Receive-pending input, used for status and interrupt only |
| ch_valid | output | 1 | A character is offered to the sink |
| ch_data | output | 8 | Character code |
| ch_ready | input | 1 | Sink takes the character this cycle |
| irq | output | 1 | Interrupt request to the system controller |
| ack_err | output | 1 | Sticky flag: acknowledge issued with nothing pending |

## Verification
The transmit path is driven with printable letters, the two printable edges (0x20 and 0x7E), ordinary control codes, DEL, form feed and high codes (0x80 and 0xFF). This shows whether the filter separates kept codes from dropped ones at every boundary. Characters are sent both with the sink always ready and with the sink held off, so order loss and stall failures show up as scoreboard mismatches. The interrupt state is tried with the enable bit clear and then set before data writes, with acknowledges both when a flag is pending and when none is, and with neutral commands and modem-control writes in between. These cases separate a real flag change from a spurious one. The receive-pending input is swept against each enable bit to show that each source is gated only by its own enable.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;
    localparam int BYTE_W   = 8;
    localparam int OFS_W    = 3;

    localparam logic [OFS_W-1:0] OFS_DATA   = 3'h0;
    localparam logic [OFS_W-1:0] OFS_ENABLE = 3'h1;
    localparam logic [OFS_W-1:0] OFS_CMD    = 3'h3;
    localparam logic [OFS_W-1:0] OFS_MODEM  = 3'h4;
    localparam logic [OFS_W-1:0] OFS_STATUS = 3'h5;

    localparam logic [BYTE_W-1:0] CMD_TX_ACK = 8'h28;
    localparam logic [BYTE_W-1:0] CODE_FF    = 8'h0C;
    localparam logic [BYTE_W-1:0] CODE_DEL   = 8'h7F;
    localparam logic [BYTE_W-1:0] CODE_SPACE = 8'h20;
    localparam logic [BYTE_W-1:0] CODE_TILDE = 8'h7E;

    localparam int EN_RX_BIT = 0;
    localparam int EN_TX_BIT = 1;
    localparam int ST_TX_BIT = 0;
    localparam int ST_RX_BIT = 1;
endpackage

// File: rtl/con_uart_filter.sv
module con_uart_filter
    import con_uart_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] code,
    output logic              keep
);
    logic printable;
    logic control;

    always_comb begin
        printable = (code >= CODE_SPACE) && (code <= CODE_TILDE);
        control   = (code < CODE_SPACE) || (code == CODE_DEL);
        keep      = (printable || control) && (code != CODE_FF);
    end
endmodule

// File: rtl/con_uart_tx_stage.sv
module con_uart_tx_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              ch_valid,
    output logic [DATA_W-1:0] ch_data,
    input  logic              ch_ready
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ch_ready) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid = 1'b1;
            st_d.data  = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_valid = st_q.valid;
    assign ch_data  = st_q.data;
    assign busy     = st_q.valid && !ch_ready;

    // R4: an offered character stays put until the sink takes it
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !ch_ready) |=> (ch_valid && $stable(ch_data)));
endmodule

// File: rtl/con_uart_irq_ctrl.sv
module con_uart_irq_ctrl
    import con_uart_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              cmd_we,
    input  logic              tx_touch,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_pend,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic              tx_pend,
    output logic              ack_err,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] cmd;
        logic              tx;
        logic              err;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_touch && st_q.en[EN_TX_BIT]) begin
            st_d.tx = 1'b1;
        end
        if (en_we) begin
            st_d.en = wdata;
            if (wdata[EN_TX_BIT]) begin
                st_d.tx = 1'b1;
            end
        end
        if (cmd_we) begin
            st_d.cmd = wdata;
            if (wdata == CMD_TX_ACK) begin
                if (st_q.tx) begin
                    st_d.tx = 1'b0;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q    = st_q.en;
    assign cmd_q   = st_q.cmd;
    assign tx_pend = st_q.tx;
    assign ack_err = st_q.err;
    assign irq     = (st_q.tx && st_q.en[EN_TX_BIT]) || (rx_pend && st_q.en[EN_RX_BIT]);

    // R6: enabling the transmit source raises its flag on the next cycle
    p_enable_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && wdata[EN_TX_BIT]) |=> tx_pend);

    // R7: an acknowledge leaves the transmit flag clear
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wdata == CMD_TX_ACK) |=> !tx_pend);

    // R7: the protocol error flag never drops outside reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |=> ack_err);

    // R8: a neutral command cannot raise or clear the flag
    p_cmd_neutral_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wdata != CMD_TX_ACK && !tx_touch) |=> $stable(tx_pend));
endmodule

// File: rtl/con_uart_front.sv
module con_uart_front
    import con_uart_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int ADDR_W = OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_stall,
    input  logic              rx_pending,
    output logic              ch_valid,
    output logic [DATA_W-1:0] ch_data,
    input  logic              ch_ready,
    output logic              irq,
    output logic              ack_err
);
    logic              hit_data;
    logic              busy;
    logic              data_acc;
    logic              keep;
    logic              load;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] cmd_q;
    logic              tx_pend;

    always_comb begin
        hit_data  = reg_wr && (reg_addr == ADDR_W'(OFS_DATA));
        reg_stall = hit_data && busy;
        data_acc  = hit_data && !busy;
        load      = data_acc && keep;
    end

    con_uart_filter #(.DATA_W(DATA_W)) u_filter (
        .code (reg_wdata),
        .keep (keep)
    );

    con_uart_tx_stage #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (reg_wdata),
        .busy      (busy),
        .ch_valid  (ch_valid),
        .ch_data   (ch_data),
        .ch_ready  (ch_ready)
    );

    con_uart_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (reg_wr && reg_addr == ADDR_W'(OFS_ENABLE)),
        .cmd_we   (reg_wr && reg_addr == ADDR_W'(OFS_CMD)),
        .tx_touch (data_acc),
        .wdata    (reg_wdata),
        .rx_pend  (rx_pending),
        .en_q     (en_q),
        .cmd_q    (cmd_q),
        .tx_pend  (tx_pend),
        .ack_err  (ack_err),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_ENABLE): reg_rdata = en_q;
            ADDR_W'(OFS_CMD):    reg_rdata = cmd_q;
            ADDR_W'(OFS_STATUS): begin
                reg_rdata[ST_TX_BIT] = tx_pend;
                reg_rdata[ST_RX_BIT] = rx_pending;
            end
            default:             reg_rdata = '0;
        endcase
    end

    // R3: a dropped form feed leaves the output empty on the next cycle
    p_ff_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && reg_wdata == CODE_FF) |=> !ch_valid);

    // R4: a stalled write never moves the offered character
    p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_stall |=> (ch_valid && $stable(ch_data)));
endmodule

// File: tb/con_uart_front_bench.sv
`timescale 1ns/1ps
module con_uart_front_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       reg_stall;
    logic       rx_pending = 1'b0;
    logic       ch_valid;
    logic [7:0] ch_data;
    logic       ch_ready = 1'b1;
    logic       irq;
    logic       ack_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit saw_stall = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    con_uart_front u_con_uart_front (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_stall(reg_stall),
        .rx_pending(rx_pending), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_ready(ch_ready), .irq(irq), .ack_err(ack_err)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit kept(logic [7:0] c);
        return (c < 8'h80) && (c != 8'h0C);
    endfunction

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        #3;
        while (reg_stall) begin
            saw_stall = 1'b1;
            @(negedge clk);
            #3;
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // driver: data write, pushing the expected character into the scoreboard
    task automatic send(logic [7:0] c, string req);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'h0; reg_wdata = c;
        #3;
        while (reg_stall) begin
            saw_stall = 1'b1;
            @(negedge clk);
            #3;
        end
        if (kept(c)) exp_q.push_back(c);
        @(negedge clk);
        reg_wr = 1'b0;
        #3;
        check(req, {7'd0, ch_valid}, {7'd0, kept(c)});
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #3;
        v = reg_rdata;
    endtask

    // monitor: pop and compare at each handshake
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && ch_valid && ch_ready) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected character", ch_data, 8'hxx);
                end else begin
                    check("R2 character order", ch_data, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #3;
        check("R1 ch_valid", {7'd0, ch_valid}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 ack_err", {7'd0, ack_err}, 8'h00);
        rd(3'h1, v); check("R1 enable", v, 8'h00);
        rd(3'h3, v); check("R1 command", v, 8'h00);
        rd(3'h5, v); check("R1 status", v, 8'h00);

        // R2 kept codes, edges included
        send(8'h48, "R2 printable");
        send(8'h20, "R2 space edge");
        send(8'h7E, "R2 tilde edge");
        send(8'h0A, "R2 control");
        send(8'h00, "R2 null");
        send(8'h7F, "R2 del");
        // R3 dropped codes
        send(8'h0C, "R3 form feed");
        send(8'h80, "R3 high edge");
        send(8'hFF, "R3 top code");
        // R5 enable clear: no flag
        rd(3'h5, v); check("R5 no flag when disabled", v, 8'h00);

        // R6 enable write raises flag, R11 irq
        wr(3'h1, 8'h02);
        rd(3'h1, v); check("R6 enable readback", v, 8'h02);
        rd(3'h5, v); check("R6 flag raised", v, 8'h01);
        check("R11 irq tx", {7'd0, irq}, 8'h01);
        // R7 ack clears
        wr(3'h3, 8'h28);
        rd(3'h5, v); check("R7 ack clears", v, 8'h00);
        check("R7 no error", {7'd0, ack_err}, 8'h00);
        check("R11 irq low", {7'd0, irq}, 8'h00);
        // R5 dropped code still flags
        send(8'h0C, "R3 form feed again");
        rd(3'h5, v); check("R5 flag on dropped code", v, 8'h01);
        // R8 neutral commands
        wr(3'h3, 8'h03);
        wr(3'h3, 8'h00);
        wr(3'h3, 8'h01);
        wr(3'h3, 8'h12);
        rd(3'h5, v); check("R8 flag unchanged", v, 8'h01);
        rd(3'h3, v); check("R8 command readback", v, 8'h12);
        // R9 modem control ignored
        wr(3'h4, 8'hFF);
        rd(3'h5, v); check("R9 status unchanged", v, 8'h01);
        rd(3'h1, v); check("R9 enable unchanged", v, 8'h02);
        rd(3'h3, v); check("R9 command unchanged", v, 8'h12);
        // R7 ack twice: second is an error
        wr(3'h3, 8'h28);
        wr(3'h3, 8'h28);
        check("R7 error set", {7'd0, ack_err}, 8'h01);
        rd(3'h5, v); check("R7 flag stays clear", v, 8'h00);

        // R10 / R11 receive pending
        @(negedge clk) rx_pending = 1'b1;
        rd(3'h5, v); check("R10 rx status", v, 8'h02);
        check("R11 rx gated off", {7'd0, irq}, 8'h00);
        wr(3'h1, 8'h01);
        rd(3'h5, v); check("R10 no tx from rx enable", v, 8'h02);
        check("R11 rx irq", {7'd0, irq}, 8'h01);
        @(negedge clk) rx_pending = 1'b0;
        #3 check("R11 rx irq drops", {7'd0, irq}, 8'h00);

        // R4 stall with sink held off
        @(negedge clk) ch_ready = 1'b0;
        send(8'h41, "R4 first held");
        saw_stall = 1'b0;
        fork
            begin
                repeat (5) @(negedge clk);
                ch_ready = 1'b1;
            end
        join_none
        send(8'h42, "R4 second after stall");
        check("R4 stall seen", {7'd0, saw_stall}, 8'h01);
        repeat (4) @(negedge clk);
        check("R4 queue drained", 8'(exp_q.size()), 8'h00);
        check("R7 error still sticky", {7'd0, ack_err}, 8'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule